// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Notifier

This block runs each time a new class of interrupt becomes pending in the system. It picks which of N processors get a wakeup kick. For each CPU it reads a 2-bit run state, a halted flag and three enable bits: external, I/O and machine-check. On a notify strobe it takes the class vector of the new event, raises a sticky hard-interrupt request flag on every CPU, and sends a one-cycle kick to the CPUs that the selection rule picks.

A running CPU is always kicked. A halted CPU is kicked only when the enable bit for the event class is set. The class is resolved by priority: service first, then I/O, then machine-check. The block does not check masking below the class level. A woken CPU checks its request again on its own side, and each CPU clears its own flag through its acknowledge input.

Top module: `wake_notifier`

## Requirements
- R1: Every notify strobe sets the hard-request flag of every CPU, including CPUs that get no kick.
- R2: Run state is coded per CPU as 0 stopped, 1 check-stop, 2 operating, 3 load (`run_state_i[2k+1:2k]`). A CPU in state 0 or 1 is never kicked.
- R3: A CPU in state 2 or 3 that is not halted is kicked for every event vector and every enable setting.
- R4: For a halted eligible CPU, if event bit 0 (service) is set, the kick follows enable bit 0 (external) alone, whatever the other event bits are. The enable bits are `enable_i[3k+2:3k]`.
- R5: For a halted eligible CPU with event bit 0 clear and event bit 1 (I/O) set, the kick follows enable bit 1 (I/O).
- R6: For a halted eligible CPU with event bits 0 and 1 clear and event bit 2 (machine-check) set, the kick follows enable bit 2 (machine-check).
- R7: For a halted eligible CPU, an all-zero event vector kicks the CPU unconditionally.
- R8: A kick is a one-cycle pulse in the cycle after the notify strobe. No kick appears without a notify strobe.
- R9: A request flag stays set until that CPU's acknowledge input is high at a clock edge, which clears it. When notify and acknowledge arrive in the same cycle, the flag stays set.
- R10: Synchronous active-high reset clears all request flags and kicks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| notify_i | input | 1 | New pending event strobe |
| event_i | input | 3 | Event class: bit0 service, bit1 I/O, bit2 machine-check |
| run_state_i | input | 2*N | Per-CPU run state |
| halted_i | input | N | Per-CPU halted flag |
| enable_i | input | 3*N | Per-CPU enables: bit0 external, bit1 I/O, bit2 machine-check |
| ack_i | input | N | Per-CPU request acknowledge |
| hard_req_o | output | N | Sticky hard-interrupt request flags |
| kick_o | output | N | One-cycle wakeup kick pulses |

## Verification
The bench builds the block with its default of four CPUs. Per CPU there are only 64 combinations of run state, halted flag and enables, and there are 8 event vectors. The bench walks all 512 pairs on every lane, rotating the assignment so that the four CPUs see different combinations in the same notify. This covers every priority order of the class bits against every enable pattern, including the case where a higher-priority class blocks a kick that a lower one would allow. Directed steps cover acknowledge, acknowledge on the same cycle as notify, and reset.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        RUN_STOPPED   = 2'd0,
        RUN_CHECKSTOP = 2'd1,
        RUN_OPERATING = 2'd2,
        RUN_LOAD      = 2'd3
    } run_state_e;

    // event class vector and per-CPU enable vector share this layout
    typedef struct packed {
        logic mchk;
        logic io;
        logic svc;
    } class_vec_t;

    localparam int CLASS_W = $bits(class_vec_t);
    localparam int STATE_W = $bits(run_state_e);

    function automatic logic state_eligible(run_state_e st);
        return (st == RUN_OPERATING) || (st == RUN_LOAD);
    endfunction

endpackage

// File: rtl/wake_class_sel.sv
module wake_class_sel
    import wake_pkg::*;
(
    input  class_vec_t event_i,
    output class_vec_t need_o    // enable a halted CPU must have; zero = none
);
    always_comb begin
        need_o = '0;
        if (event_i.svc)       need_o.svc  = 1'b1;
        else if (event_i.io)   need_o.io   = 1'b1;
        else if (event_i.mchk) need_o.mchk = 1'b1;
    end
endmodule

// File: rtl/wake_lane.sv
module wake_lane
    import wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       notify_i,
    input  class_vec_t need_i,
    input  run_state_e state_i,
    input  logic       halted_i,
    input  class_vec_t enable_i,
    input  logic       ack_i,
    output logic       hard_req_o,
    output logic       kick_o
);
    logic eligible;
    logic halted_ok;
    logic kick_d;

    always_comb begin
        eligible  = state_eligible(state_i);
        halted_ok = (need_i == '0) || ((need_i & enable_i) != '0);
        kick_d    = notify_i && eligible && (!halted_i || halted_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hard_req_o <= 1'b0;
            kick_o     <= 1'b0;
        end else begin
            kick_o <= kick_d;
            if (notify_i)   hard_req_o <= 1'b1;
            else if (ack_i) hard_req_o <= 1'b0;
        end
    end

    assert_req_all_R1: assert property (@(posedge clk) disable iff (rst)
        notify_i |=> hard_req_o);
    assert_ineligible_R2: assert property (@(posedge clk) disable iff (rst)
        (notify_i && (state_i == RUN_STOPPED || state_i == RUN_CHECKSTOP)) |=> !kick_o);
    assert_running_R3: assert property (@(posedge clk) disable iff (rst)
        (notify_i && (state_i == RUN_OPERATING || state_i == RUN_LOAD) && !halted_i) |=> kick_o);
    assert_kick_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !notify_i |=> !kick_o);
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !notify_i) |=> !hard_req_o);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (hard_req_o && !ack_i) |=> hard_req_o);
endmodule

// File: rtl/wake_notifier.sv
module wake_notifier
    import wake_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 notify_i,
    input  logic [CLASS_W-1:0]   event_i,
    input  logic [STATE_W*N-1:0] run_state_i,
    input  logic [N-1:0]         halted_i,
    input  logic [CLASS_W*N-1:0] enable_i,
    input  logic [N-1:0]         ack_i,
    output logic [N-1:0]         hard_req_o,
    output logic [N-1:0]         kick_o
);
    class_vec_t need;

    wake_class_sel u_sel (
        .event_i (class_vec_t'(event_i)),
        .need_o  (need)
    );

    for (genvar k = 0; k < N; k++) begin : g_lane
        wake_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .notify_i   (notify_i),
            .need_i     (need),
            .state_i    (run_state_e'(run_state_i[STATE_W*k +: STATE_W])),
            .halted_i   (halted_i[k]),
            .enable_i   (class_vec_t'(enable_i[CLASS_W*k +: CLASS_W])),
            .ack_i      (ack_i[k]),
            .hard_req_o (hard_req_o[k]),
            .kick_o     (kick_o[k])
        );
    end

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (hard_req_o == '0 && kick_o == '0));
endmodule

// File: tb/wake_notifier_test.sv
module wake_notifier_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic notify_i = 1'b0;
    logic [2:0] event_i = '0;
    logic [2*N-1:0] run_state_i = '0;
    logic [N-1:0] halted_i = '0;
    logic [3*N-1:0] enable_i = '0;
    logic [N-1:0] ack_i = '0;
    logic [N-1:0] hard_req_o;
    logic [N-1:0] kick_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wake_notifier #(.N(N)) uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_kick(logic [1:0] st, logic h, logic [2:0] en, logic [2:0] ev);
        if (st < 2) return 1'b0;
        if (!h) return 1'b1;
        if (ev[0]) return en[0];
        if (ev[1]) return en[1];
        if (ev[2]) return en[2];
        return 1'b1;
    endfunction

    function automatic string tag_of(logic [1:0] st, logic h, logic [2:0] ev);
        if (st < 2) return "R2";
        if (!h) return "R3";
        if (ev[0]) return "R4";
        if (ev[1]) return "R5";
        if (ev[2]) return "R6";
        return "R7";
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] expk;
        repeat (3) @(negedge clk);
        check("R10 req", hard_req_o, 0);
        check("R10 kick", kick_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle", kick_o, 0);

        for (int ev = 0; ev < 8; ev++) begin
            for (int idx = 0; idx < 64; idx++) begin
                for (int k = 0; k < N; k++) begin
                    int c;
                    c = (idx + k * 23) % 64;
                    run_state_i[2*k +: 2] = c[1:0];
                    halted_i[k] = c[2];
                    enable_i[3*k +: 3] = c[5:3];
                    expk[k] = exp_kick(c[1:0], c[2], c[5:3], ev[2:0]);
                end
                event_i = ev[2:0];
                notify_i = 1'b1;
                @(negedge clk);
                notify_i = 1'b0;
                for (int k = 0; k < N; k++)
                    check(tag_of(run_state_i[2*k +: 2], halted_i[k], event_i), kick_o[k], expk[k]);
                check("R1", hard_req_o, {N{1'b1}});
                @(negedge clk);
                check("R8 pulse", kick_o, 0);
                check("R9 hold", hard_req_o, {N{1'b1}});
                ack_i = {N{1'b1}};
                @(negedge clk);
                ack_i = '0;
                check("R9 clear", hard_req_o, 0);
            end
        end

        // partial ack, and ack colliding with notify
        run_state_i = '0;
        notify_i = 1'b1;
        @(negedge clk);
        notify_i = 1'b0;
        check("R1 stopped", hard_req_o, {N{1'b1}});
        check("R2 stopped", kick_o, 0);
        ack_i = 4'b0101;
        @(negedge clk);
        check("R9 partial", hard_req_o, 4'b1010);
        ack_i = 4'b1111;
        notify_i = 1'b1;
        @(negedge clk);
        notify_i = 1'b0;
        ack_i = '0;
        check("R9 collide", hard_req_o, 4'b1111);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 midrun", hard_req_o, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule